// File: doc/BRIEF.md
# Dual-Clock FIFO Almost-Full Flag Generator

This block produces the almost-full status for a FIFO whose producer and consumer run on unrelated clocks. It keeps its own write position in the write domain and a read position in the read domain, and compares the two against a threshold of `DEPTH - (Y+1)` words. `Y` is the almost-full offset. The flag `af_n` is active low. It is LOW while the stored word count exceeds the threshold and HIGH while the count is at or below it. The storage array, the data paths and every other status flag belong to the surrounding FIFO. One instance serves one FIFO, so a device with two FIFOs carries two independent offset registers.

The read position crosses into the write domain as Gray code through a chain of `SYNC_STAGES` flops, two by default. A write that pushes the count over the threshold pulls the flag LOW right after that write-clock edge. A read that brings the count back down to the threshold raises the flag only on the second write-clock edge after the read. If the first following edge lands too close to the read, one edge later is also acceptable. The offset is chosen by `fsel` while `rst_n` is low. Code 00 selects the loadable offset, which is written over the write-side strobe `cfg_wr`.

Top module: `afp_almost_full`

## Requirements
- R1: While `rst_n` is low for at least two edges of each clock, both positions clear. The first sample after release shows `af_n` HIGH.
- R2: `fsel` sampled during reset selects Y: 2'b11 gives 64, 2'b10 gives 16 and 2'b01 gives 8. With `DEPTH=1024` the threshold is 1024-(Y+1), so `af_n` is HIGH at a count of 959/1007/1015 and LOW one word above.
- R3: Changing `fsel` after reset release has no effect on the threshold.
- R4: With `fsel`=2'b00 at reset, Y is 0 until a `cfg_wr` pulse loads `cfg_off`, and each such pulse sets Y to that value. In the fixed-offset modes, `cfg_wr` is ignored.
- R5: A write that takes the count from the threshold to threshold+1 drives `af_n` LOW right after that write-clock edge, with no synchronization delay.
- R6: A read that takes the count from threshold+1 to the threshold raises `af_n` at the `SYNC_STAGES`-th write-clock rising edge after the read and not earlier. If the first following edge is closer to the read than the skew window, one edge later is also accepted.
- R7: Both positions wrap modulo 2·DEPTH. The crossed read position is Gray coded, so each read flips exactly one bit of it, and the flag stays correct after the positions wrap.
- R8: Under legal traffic (no write when full, no read when empty), the count never exceeds DEPTH. Within `SYNC_STAGES`+1 write edges after traffic stops, `af_n` equals (count ≤ threshold).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-side clock; flag domain |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Synchronous active-low reset, seen by both domains |
| wr_en | input | 1 | One word written on this write-clock edge (already qualified by the FIFO) |
| rd_en | input | 1 | One word read on this read-clock edge (already qualified by the FIFO) |
| fsel | input | 2 | Offset select, sampled while `rst_n` is low |
| cfg_wr | input | 1 | Load strobe for the programmable offset, write clock |
| cfg_off | input | $clog2(DEPTH) | Offset value loaded by `cfg_wr` |
| af_n | output | 1 | Almost-full flag, LOW when count exceeds the threshold |

## Verification
The bench attacks the one-word boundary on each side of every threshold. A design with an off-by-one compare would flip the flag a word early or late. The bench also times each deassertion in write-clock edges from the read. A design that skipped a synchronizer stage would release on the first edge, and one with an extra stage would release on the third. It loads an offset in a fixed mode and changes `fsel` after reset, which catches a design that keeps listening to either input. A long back-and-forth run that wraps the positions exposes broken Gray decoding or a wrong pointer width as a wrong flag after the wrap.

// File: rtl/afp_pkg.sv
`timescale 1ns/100ps
// Shared definitions for the almost-full flag block.
// Assumes: the offset select codes below are fixed by the board strapping.
package afp_pkg;

    typedef enum logic [1:0] {
        SEL_LOAD = 2'b00,
        SEL_8    = 2'b01,
        SEL_16   = 2'b10,
        SEL_64   = 2'b11
    } fsel_e;

    // Map a select code to its fixed offset; the loadable mode starts at 0.
    function automatic int unsigned sel_offset(fsel_e s);
        case (s)
            SEL_64:  return 64;
            SEL_16:  return 16;
            SEL_8:   return 8;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/afp_offset_sel.sv
`timescale 1ns/100ps
// Offset register: captures the select pins while reset is low and, in the
// loadable mode only, accepts new values from the write-side load strobe.
// Assumes: fsel is stable during the last reset edge; OFF_W >= 7.
module afp_offset_sel #(
    parameter int OFF_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       fsel,
    input  logic             cfg_wr,
    input  logic [OFF_W-1:0] cfg_off,
    output logic [OFF_W-1:0] offset
);
    import afp_pkg::*;

    logic mode_load;

    // Capture the mode and fixed offset in reset; accept loads afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_load <= (fsel_e'(fsel) == SEL_LOAD);
            offset    <= OFF_W'(sel_offset(fsel_e'(fsel)));
        end else if (mode_load && cfg_wr) begin
            offset    <= cfg_off;
        end
    end

endmodule

// File: rtl/afp_rd_side.sv
`timescale 1ns/100ps
// Read-domain position counter, published as a registered Gray code so
// that only one bit changes per read.
// Assumes: rd_en is never high while the FIFO is empty.
module afp_rd_side #(
    parameter int PTR_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    output logic [PTR_W-1:0] rd_gray
);
    logic [PTR_W-1:0] rd_bin;
    logic [PTR_W-1:0] rd_next;

    // Next binary position.
    always_comb begin
        rd_next = rd_en ? rd_bin + PTR_W'(1) : rd_bin;
    end

    // Register the binary position and its Gray image together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_bin  <= '0;
            rd_gray <= '0;
        end else begin
            rd_bin  <= rd_next;
            rd_gray <= rd_next ^ (rd_next >> 1);
        end
    end

endmodule

// File: rtl/afp_sync.sv
`timescale 1ns/100ps
// Multi-flop synchronizer for a Gray-coded bus into the destination clock.
// Assumes: the source changes at most one bit between destination edges
// or holds long enough, so every captured word is a valid code.
module afp_sync #(
    parameter int W      = 11,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // First stage samples the foreign-domain bus.
            always_ff @(posedge clk) begin
                if (!rst_n) stage[g] <= '0;
                else        stage[g] <= d;
            end
        end else begin : g_next
            // Later stages let a metastable first stage settle.
            always_ff @(posedge clk) begin
                if (!rst_n) stage[g] <= '0;
                else        stage[g] <= stage[g-1];
            end
        end
    end

    assign q = stage[STAGES-1];

endmodule

// File: rtl/afp_wr_side.sv
`timescale 1ns/100ps
// Write-domain position counter, fill computation and threshold compare.
// The flag is decoded from registered state, so a write shows up right
// after its edge while a read shows up only after the synchronizer.
// Assumes: wr_en is never high while the FIFO is full.
module afp_wr_side #(
    parameter int DEPTH = 1024,
    parameter int PTR_W = 11,
    parameter int OFF_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] rd_gray_s,
    input  logic [OFF_W-1:0] offset,
    output logic [PTR_W-1:0] fill,
    output logic             af_n
);
    localparam logic [PTR_W-1:0] DEPTH_M1 = PTR_W'(DEPTH - 1);

    logic [PTR_W-1:0] wr_bin;
    logic [PTR_W-1:0] rd_bin_s;
    logic [PTR_W-1:0] thresh;

    // Advance the write position on every accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) wr_bin <= '0;
        else if (wr_en) wr_bin <= wr_bin + PTR_W'(1);
    end

    // Decode the synchronized Gray read position back to binary.
    always_comb begin
        for (int i = 0; i < PTR_W; i++) begin
            rd_bin_s[i] = ^(rd_gray_s >> i);
        end
    end

    // Fill level, threshold and flag decode.
    always_comb begin
        fill   = wr_bin - rd_bin_s;
        thresh = DEPTH_M1 - PTR_W'(offset);
        af_n   = (fill <= thresh);
    end

endmodule

// File: rtl/afp_almost_full.sv
`timescale 1ns/100ps
// Almost-full flag generator for a dual-clock FIFO of DEPTH words
// (1024, 4096 or 16384). Flag af_n is active low and lives in wr_clk.
// Assumes: rst_n is held low for at least two edges of each clock; the
// strobes are already qualified against full and empty by the FIFO.
module afp_almost_full #(
    parameter int DEPTH       = 1024,
    parameter int SYNC_STAGES = 2
) (
    input  logic                     wr_clk,
    input  logic                     rd_clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic                     rd_en,
    input  logic [1:0]               fsel,
    input  logic                     cfg_wr,
    input  logic [$clog2(DEPTH)-1:0] cfg_off,
    output logic                     af_n
);
    localparam int OFF_W = $clog2(DEPTH);
    localparam int PTR_W = OFF_W + 1;

    logic [OFF_W-1:0] offset;
    logic [PTR_W-1:0] rd_gray;
    logic [PTR_W-1:0] rd_gray_s;
    logic [PTR_W-1:0] fill;

    afp_offset_sel #(.OFF_W(OFF_W)) u_off (
        .clk(wr_clk), .rst_n(rst_n), .fsel(fsel),
        .cfg_wr(cfg_wr), .cfg_off(cfg_off), .offset(offset)
    );

    afp_rd_side #(.PTR_W(PTR_W)) u_rd (
        .clk(rd_clk), .rst_n(rst_n), .rd_en(rd_en), .rd_gray(rd_gray)
    );

    afp_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(wr_clk), .rst_n(rst_n), .d(rd_gray), .q(rd_gray_s)
    );

    afp_wr_side #(.DEPTH(DEPTH), .PTR_W(PTR_W), .OFF_W(OFF_W)) u_wr (
        .clk(wr_clk), .rst_n(rst_n), .wr_en(wr_en), .rd_gray_s(rd_gray_s),
        .offset(offset), .fill(fill), .af_n(af_n)
    );

endmodule

// File: rtl/afp_checker.sv
`timescale 1ns/100ps
// Property checker for afp_almost_full, attached by the bind below.
// Assumes: legal strobes (no write when full, no read when empty).
module afp_checker #(
    parameter int DEPTH = 1024,
    parameter int OFF_W = 10,
    parameter int PTR_W = 11
) (
    input logic             wr_clk,
    input logic             rd_clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             cfg_wr,
    input logic             af_n,
    input logic [PTR_W-1:0] rd_gray,
    input logic [PTR_W-1:0] rd_gray_s,
    input logic [PTR_W-1:0] fill,
    input logic [OFF_W-1:0] offset
);
    // R7: the crossed read code moves by at most one bit per read edge.
    p_gray_step_r7: assert property (@(posedge rd_clk) disable iff (!rst_n)
        $onehot0(rd_gray ^ $past(rd_gray)));

    // R8: the fill level never goes past the FIFO depth.
    p_fill_bound_r8: assert property (@(posedge wr_clk) disable iff (!rst_n)
        fill <= PTR_W'(DEPTH));

    // R5: the flag only falls because of a write or a new offset.
    p_fall_on_write_r5: assert property (@(posedge wr_clk) disable iff (!rst_n)
        $fell(af_n) |-> ($past(wr_en) || $past(cfg_wr)));

    // R6: the flag only rises after a new read position arrives.
    p_rise_on_read_r6: assert property (@(posedge wr_clk) disable iff (!rst_n)
        $rose(af_n) |-> (!$stable(rd_gray_s) || $past(cfg_wr)));

    // R4: the offset changes only on a load strobe once out of reset.
    p_offset_hold_r4: assert property (@(posedge wr_clk) disable iff (!rst_n)
        !$stable(offset) |-> $past(cfg_wr));

endmodule

bind afp_almost_full afp_checker #(
    .DEPTH(DEPTH), .OFF_W(OFF_W), .PTR_W(PTR_W)
) u_chk (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .wr_en(wr_en),
    .cfg_wr(cfg_wr), .af_n(af_n), .rd_gray(rd_gray), .rd_gray_s(rd_gray_s),
    .fill(fill), .offset(offset)
);

// File: tb/tb_afp_almost_full.sv
`timescale 1ns/100ps
module tb_afp_almost_full;
    localparam int  DEPTH   = 1024;
    localparam int  SYNC    = 2;
    localparam int  OFF_W   = $clog2(DEPTH);
    localparam real SKEW_NS = 0.5;

    logic wr_clk, rd_clk, rst_n, wr_en, rd_en, cfg_wr, af_n;
    logic [1:0] fsel;
    logic [OFF_W-1:0] cfg_off;

    int total = 0;
    int bad   = 0;
    int count = 0;
    int wr_edges = 0;

    afp_almost_full #(.DEPTH(DEPTH), .SYNC_STAGES(SYNC)) dut (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .wr_en(wr_en),
        .rd_en(rd_en), .fsel(fsel), .cfg_wr(cfg_wr), .cfg_off(cfg_off),
        .af_n(af_n)
    );

    // 250 MHz write clock: rising edges at 2 + 4k ns.
    initial begin
        wr_clk = 0;
        forever #2 wr_clk = ~wr_clk;
    end

    // Read clock, rising at 0.9 + 5.6j ns: never coincides with wr_clk.
    initial begin
        rd_clk = 0;
        #0.9;
        forever begin
            rd_clk = 1; #2.8;
            rd_clk = 0; #2.8;
        end
    end

    always @(posedge wr_clk) wr_edges <= wr_edges + 1;

    initial begin
        #(200000 * 4);
        total++; bad++;
        $display("FAIL watchdog: got %0d expected %0d", 0, 1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    function automatic int thr_of(int y);
        return DEPTH - (y + 1);
    endfunction

    function automatic logic exp_flag(int cnt, int thr);
        return (cnt <= thr);
    endfunction

    task automatic chk(input int act, input int exp, input string msg);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d", msg, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] s);
        @(negedge wr_clk);
        rst_n = 0; fsel = s; wr_en = 0; rd_en = 0; cfg_wr = 0; cfg_off = '0;
        repeat (3) @(posedge rd_clk);
        @(negedge wr_clk);
        rst_n = 1;
        count = 0;
    endtask

    task automatic write_n(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge wr_clk); wr_en = 1; count++;
        end
        @(negedge wr_clk); wr_en = 0;
    endtask

    task automatic read_n(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge rd_clk); rd_en = 1; count--;
        end
        @(negedge rd_clk); rd_en = 0;
    endtask

    task automatic settle();
        repeat (SYNC + 2) @(negedge wr_clk);
    endtask

    task automatic fill_to(input int t);
        if (count < t) write_n(t - count);
        else if (count > t) read_n(count - t);
    endtask

    task automatic cfg_load(input int v);
        @(negedge wr_clk); cfg_off = OFF_W'(v); cfg_wr = 1;
        @(negedge wr_clk); cfg_wr = 0;
    endtask

    // One read; count write edges until the flag rises (R6).
    task automatic timed_read(input int thr);
        real t_rd, t_first;
        int  e0, seen;
        logic found;
        @(negedge rd_clk); rd_en = 1; count--;
        @(posedge rd_clk);
        t_rd = $realtime; e0 = wr_edges;
        found = 0; seen = 0;
        fork
            begin @(negedge rd_clk); rd_en = 0; end
            begin
                for (int k = 0; k < 6; k++) begin
                    @(negedge wr_clk);
                    if (!found && af_n) begin found = 1; seen = wr_edges - e0; end
                end
            end
        join
        t_first = 2.0 + 4.0 * ($floor((t_rd - 2.0) / 4.0) + 1.0);
        if (seen == SYNC + 1 && (t_first - t_rd) < SKEW_NS)
            chk(seen, SYNC + 1, "R6 release edge (skewed)");
        else
            chk(seen, SYNC, "R6 release edge");
        chk(int'(af_n), int'(exp_flag(count, thr)), "R6 flag after release");
    endtask

    // Exercise both sides of one threshold.
    task automatic boundary(input int thr, input string rq);
        fill_to(thr);
        settle();
        chk(int'(af_n), 1, {rq, " at threshold"});
        write_n(1);
        chk(int'(af_n), 0, "R5 immediate assert");
        timed_read(thr);
        write_n(1);
        chk(int'(af_n), 0, {rq, " one above"});
    endtask

    task automatic rand_traffic(input int ops, input int thr);
        int r, n;
        for (int i = 0; i < ops; i++) begin
            r = $urandom % 3;
            n = 1 + ($urandom % 6);
            if (r == 0) begin
                if (count + n > DEPTH) n = DEPTH - count;
                if (n > 0) write_n(n);
            end else if (r == 1) begin
                if (n > count) n = count;
                if (n > 0) read_n(n);
            end
            settle();
            chk(int'(af_n), int'(exp_flag(count, thr)), "R8 settled flag");
        end
    endtask

    initial begin
        void'($urandom(32'h5eed_0101));
        rst_n = 0; wr_en = 0; rd_en = 0; cfg_wr = 0; cfg_off = '0; fsel = 2'b11;

        // Offset 64, then move fsel to prove it is ignored (R3).
        do_reset(2'b11);
        @(negedge wr_clk);
        chk(int'(af_n), 1, "R1 reset flag");
        fsel = 2'b01;
        boundary(thr_of(64), "R2 Y=64");
        fill_to(thr_of(64) + 1);
        settle();
        chk(int'(af_n), 0, "R3 fsel change ignored");

        // Offset 16 with random traffic around the threshold (R8).
        do_reset(2'b10);
        boundary(thr_of(16), "R2 Y=16");
        fill_to(thr_of(16) - 8);
        rand_traffic(60, thr_of(16));
        fill_to(40);
        fork
            write_n(30);
            read_n(30);
        join
        settle();
        chk(int'(af_n), int'(exp_flag(count, thr_of(16))), "R8 concurrent traffic");

        // Offset 8: a load strobe must not move the threshold (R4).
        do_reset(2'b01);
        cfg_load(200);
        boundary(thr_of(8), "R4 load ignored Y=8");

        // Loadable mode, offset 0 before any load (R4).
        do_reset(2'b00);
        boundary(thr_of(0), "R4 default Y=0");

        // Loadable mode, offset 100, then wrap the positions (R7).
        do_reset(2'b00);
        cfg_load(100);
        boundary(thr_of(100), "R4 loaded Y=100");
        fill_to(0);
        for (int c = 0; c < 3; c++) begin
            write_n(700);
            read_n(700);
        end
        settle();
        chk(int'(af_n), 1, "R7 flag after wrap");
        boundary(thr_of(100), "R7 boundary after wrap");
        rand_traffic(30, thr_of(100));

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule